// File: doc/BRIEF.md
# Inter-processor interrupt destination resolver

This block takes one interrupt command issued by a sending agent and decides which of a parameterized set of local interrupt agents must receive it. The command arrives as a 32-bit low command word, a destination ID and the sender's own ID, together with a live snapshot of every agent's state: its physical ID, its logical destination byte, its destination format nibble, its focus-disable and focus-hit flags, and its arbitration priority.

The resolver decodes the destination shorthand, matches physical or logical destinations (flat and cluster formats), and runs lowest-priority arbitration when the delivery mode asks for it. A focus agent is preferred over the priority comparison. One clock after a command strobe it presents a delivery mask, the delivery mode, vector, trigger and level, and an error flag that the sender reads back when nobody accepted the command.

Top module: `ipi_dest_resolver`

## Requirements
- R1: The command word is decoded as vector in bits 7:0, delivery mode in bits 10:8, logical flag in bit 11, level in bit 14, trigger in bit 15 and shorthand in bits 19:18. Vector, mode, trigger and level appear unchanged on the outputs with the result.
- R2: A result is presented (dlv_valid high) exactly one clock after each cmd_valid strobe and for that one cycle only. While dlv_valid is low the delivery mask is all zeros.
- R3: A command with delivery mode 5 (init), level 0 and trigger 1 is a resync. It is discarded: empty mask, error flag cleared, whatever the shorthand.
- R4: Shorthand 1 delivers to every agent whose ID equals the sender ID, in any mode.
- R5: Shorthand 2 delivers to all agents. Shorthand 3 delivers to all agents whose ID differs from the sender ID.
- R6: With shorthand 0 and a physical destination (bit 11 clear), a destination of all ones reaches every agent. Any other value reaches only agents whose ID equals it.
- R7: Delivery mode 1 (lowest priority) with shorthand 0 and a physical destination reaches nobody and flags an error.
- R8: In logical mode a destination of 0 reaches nobody. An agent with format nibble 0xF matches when the destination ANDed with its logical byte is nonzero, and every matching agent receives the command.
- R9: An agent with format nibble 0x0 (cluster) matches a destination of 0xFF, or a destination whose upper nibble equals that of its logical byte while the lower nibbles share a set bit. Any other format nibble never matches a logical destination.
- R10: In mode 1, unless the shorthand is 1, exactly one agent is chosen among the candidates. The lowest-indexed candidate with focus-hit set and focus-disable clear wins if one exists.
- R11: Without a focus candidate, the candidate with the numerically smallest priority wins, and a tie goes to the lowest index.
- R12: In mode 1, shorthand 2 arbitrates among all agents and shorthand 3 among all agents except those with the sender's ID, instead of broadcasting.
- R13: send_err is updated with every result: it is set when a non-resync command reached no agent and cleared otherwise. It holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_word | input | 32 | Low command word |
| cmd_dest | input | ID_W | Destination ID |
| sender_id | input | ID_W | Physical ID of the sending agent |
| agent_id | input | N_AGENTS*ID_W | Physical ID per agent, agent i at [i*ID_W +: ID_W] |
| agent_ldr | input | N_AGENTS*ID_W | Logical destination byte per agent |
| agent_fmt | input | N_AGENTS*4 | Destination format nibble per agent |
| agent_focus_off | input | N_AGENTS | Focus checking disabled per agent |
| agent_focus_hit | input | N_AGENTS | Agent already holds this vector (focus hit) |
| agent_prio | input | N_AGENTS*PRIO_W | Arbitration priority per agent |
| dlv_valid | output | 1 | Result present |
| dlv_mask | output | N_AGENTS | Agents receiving the command |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_trig | output | 1 | Trigger mode bit |
| dlv_level | output | 1 | Level bit |
| send_err | output | 1 | Send-accept error of the last result |

## Verification
The bench builds the block with its defaults: four agents, 8-bit IDs and 8-bit priorities. Four agents are enough to set up a priority tie between two candidates while a third holds a lower index outside the candidate set. They also allow a focus agent that beats a lower priority, a disabled focus, and cluster matches where two agents share an upper nibble and a third does not. The 8-bit ID width gives the real nibble split for cluster matching. A random phase draws agent IDs from a small range, so duplicate IDs, self exclusion with several agents and mixed formats occur against the behavioural model.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_INIT   = 3'd5;

  localparam logic [3:0] FMT_CLUSTER = 4'h0;
  localparam logic [3:0] FMT_FLAT    = 4'hF;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       logical;
    logic       level;
    logic       trig;
    shorthand_e sh;
  } ipi_cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
  import ipi_res_pkg::*;
(
  input  logic [31:0] word,
  output ipi_cmd_t    cmd,
  output logic        resync
);

  logic unused_word_bits;

  always_comb begin
    cmd.vector  = word[7:0];
    cmd.mode    = word[10:8];
    cmd.logical = word[11];
    cmd.level   = word[14];
    cmd.trig    = word[15];
    cmd.sh      = shorthand_e'(word[19:18]);
    resync      = (word[10:8] == DM_INIT) && !word[14] && word[15];
  end

  assign unused_word_bits = ^{word[31:20], word[17:16], word[13:12]};

endmodule

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
  import ipi_res_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ID_W     = 8
) (
  input  ipi_cmd_t                   cmd,
  input  logic [ID_W-1:0]            dest,
  input  logic [ID_W-1:0]            self_id,
  input  logic [N_AGENTS*ID_W-1:0]   ids,
  input  logic [N_AGENTS*ID_W-1:0]   ldrs,
  input  logic [N_AGENTS*4-1:0]      fmts,
  output logic [N_AGENTS-1:0]        cand
);

  localparam int HALF = ID_W / 2;

  logic dest_all;
  assign dest_all = (dest == {ID_W{1'b1}});

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    logic [ID_W-1:0] id_i;
    logic [ID_W-1:0] ldr_i;
    logic [3:0]      fmt_i;
    logic            flat_hit;
    logic            clus_hit;
    logic            log_hit;
    logic            phys_hit;

    assign id_i  = ids[i*ID_W +: ID_W];
    assign ldr_i = ldrs[i*ID_W +: ID_W];
    assign fmt_i = fmts[i*4 +: 4];

    always_comb begin
      flat_hit = |(dest & ldr_i);
      clus_hit = dest_all ||
                 ((dest[ID_W-1:HALF] == ldr_i[ID_W-1:HALF]) &&
                  (|(dest[HALF-1:0] & ldr_i[HALF-1:0])));
      case (fmt_i)
        FMT_FLAT:    log_hit = flat_hit;
        FMT_CLUSTER: log_hit = clus_hit;
        default:     log_hit = 1'b0;
      endcase
      phys_hit = dest_all || (id_i == dest);

      case (cmd.sh)
        SH_DEST: begin
          if (cmd.logical)                cand[i] = log_hit;
          else if (cmd.mode == DM_LOWEST) cand[i] = 1'b0;
          else                            cand[i] = phys_hit;
        end
        SH_SELF:   cand[i] = (id_i == self_id);
        SH_ALL:    cand[i] = 1'b1;
        SH_OTHERS: cand[i] = (id_i != self_id);
        default:   cand[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
  parameter int N_AGENTS = 4,
  parameter int PRIO_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_AGENTS-1:0]        cand,
  input  logic [N_AGENTS-1:0]        focus_hit,
  input  logic [N_AGENTS-1:0]        focus_off,
  input  logic [N_AGENTS*PRIO_W-1:0] prio,
  output logic [N_AGENTS-1:0]        pick
);

  localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [N_AGENTS-1:0] focus_cand;
  logic [N_AGENTS-1:0] focus_pick;
  logic [N_AGENTS-1:0] prio_pick;
  logic                prio_found;
  logic [PRIO_W-1:0]   prio_best;
  logic [IDX_W-1:0]    prio_idx;

  assign focus_cand = cand & focus_hit & ~focus_off;

  // lowest-indexed focus candidate
  always_comb begin
    focus_pick = '0;
    for (int i = N_AGENTS - 1; i >= 0; i--) begin
      if (focus_cand[i]) begin
        focus_pick    = '0;
        focus_pick[i] = 1'b1;
      end
    end
  end

  // smallest priority, strict compare keeps the lowest index on ties
  always_comb begin
    prio_found = 1'b0;
    prio_best  = '0;
    prio_idx   = '0;
    for (int i = 0; i < N_AGENTS; i++) begin
      if (cand[i] && (!prio_found || (prio[i*PRIO_W +: PRIO_W] < prio_best))) begin
        prio_found = 1'b1;
        prio_best  = prio[i*PRIO_W +: PRIO_W];
        prio_idx   = IDX_W'(i);
      end
    end
    prio_pick = '0;
    if (prio_found) prio_pick[prio_idx] = 1'b1;
  end

  assign pick = (|focus_cand) ? focus_pick : prio_pick;

  AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)) else $error("pick not single");                      // R11
  AST_PICK_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> ((pick & cand) != '0)) else $error("pick outside set");  // R10
  AST_FOCUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|focus_cand) |-> ((pick & focus_cand) != '0)) else $error("focus lost"); // R10

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_res_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ID_W     = 8,
  parameter int PRIO_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [31:0]                cmd_word,
  input  logic [ID_W-1:0]            cmd_dest,
  input  logic [ID_W-1:0]            sender_id,
  input  logic [N_AGENTS*ID_W-1:0]   agent_id,
  input  logic [N_AGENTS*ID_W-1:0]   agent_ldr,
  input  logic [N_AGENTS*4-1:0]      agent_fmt,
  input  logic [N_AGENTS-1:0]        agent_focus_off,
  input  logic [N_AGENTS-1:0]        agent_focus_hit,
  input  logic [N_AGENTS*PRIO_W-1:0] agent_prio,
  output logic                       dlv_valid,
  output logic [N_AGENTS-1:0]        dlv_mask,
  output logic [2:0]                 dlv_mode,
  output logic [7:0]                 dlv_vector,
  output logic                       dlv_trig,
  output logic                       dlv_level,
  output logic                       send_err
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ipi_cmd_t            cmd;
  logic                resync;
  logic [N_AGENTS-1:0] cand;
  logic [N_AGENTS-1:0] pick;
  logic                use_pick;
  logic [N_AGENTS-1:0] mask_d;
  logic                err_d;

  ipi_cmd_decode u_decode (
    .word   (cmd_word),
    .cmd    (cmd),
    .resync (resync)
  );

  ipi_agent_match #(.N_AGENTS(N_AGENTS), .ID_W(ID_W)) u_match (
    .cmd     (cmd),
    .dest    (cmd_dest),
    .self_id (sender_id),
    .ids     (agent_id),
    .ldrs    (agent_ldr),
    .fmts    (agent_fmt),
    .cand    (cand)
  );

  ipi_lowest_pick #(.N_AGENTS(N_AGENTS), .PRIO_W(PRIO_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cand      (cand),
    .focus_hit (agent_focus_hit),
    .focus_off (agent_focus_off),
    .prio      (agent_prio),
    .pick      (pick)
  );

  // next-state
  always_comb begin
    use_pick = (cmd.mode == DM_LOWEST) && (cmd.sh != SH_SELF);
    if (resync)        mask_d = '0;
    else if (use_pick) mask_d = pick;
    else               mask_d = cand;
    err_d = !resync && (mask_d == '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dlv_valid  <= 1'b0;
      dlv_mask   <= '0;
      dlv_mode   <= '0;
      dlv_vector <= '0;
      dlv_trig   <= 1'b0;
      dlv_level  <= 1'b0;
      send_err   <= 1'b0;
    end else begin
      dlv_valid <= cmd_valid;
      dlv_mask  <= cmd_valid ? mask_d : '0;
      if (cmd_valid) begin
        dlv_mode   <= cmd.mode;
        dlv_vector <= cmd.vector;
        dlv_trig   <= cmd.trig;
        dlv_level  <= cmd.level;
        send_err   <= err_d;
      end
    end
  end

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dlv_valid |-> (dlv_mask == '0)) else $error("mask while idle");      // R2
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_valid |=> dlv_valid) else $error("result missing");               // R2
  AST_RESYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_valid && resync) |=> (dlv_mask == '0 && !send_err))
    else $error("resync delivered");                                      // R3
  AST_PHYS_LOWEST_REJECT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_valid && !resync && cmd.mode == DM_LOWEST && !cmd.logical && cmd.sh == SH_DEST)
      |=> (dlv_mask == '0 && send_err)) else $error("physical lowest");   // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cmd_valid |=> $stable(send_err)) else $error("err moved");           // R13
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dlv_valid && dlv_mask != '0) |-> !send_err) else $error("err with delivery"); // R13

endmodule

// File: tb/ipi_dest_resolver_bench.sv
module ipi_dest_resolver_bench;

  localparam int N  = 4;
  localparam int IW = 8;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic [31:0]     cmd_word = '0;
  logic [IW-1:0]   cmd_dest = '0;
  logic [IW-1:0]   sender_id = '0;
  logic [N*IW-1:0] agent_id;
  logic [N*IW-1:0] agent_ldr;
  logic [N*4-1:0]  agent_fmt;
  logic [N-1:0]    agent_focus_off;
  logic [N-1:0]    agent_focus_hit;
  logic [N*PW-1:0] agent_prio;
  logic            dlv_valid;
  logic [N-1:0]    dlv_mask;
  logic [2:0]      dlv_mode;
  logic [7:0]      dlv_vector;
  logic            dlv_trig;
  logic            dlv_level;
  logic            send_err;

  int b_id[N], b_ldr[N], b_fmt[N], b_off[N], b_hit[N], b_pri[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      agent_id[i*IW +: IW]  = IW'(b_id[i]);
      agent_ldr[i*IW +: IW] = IW'(b_ldr[i]);
      agent_fmt[i*4 +: 4]   = 4'(b_fmt[i]);
      agent_focus_off[i]    = b_off[i][0];
      agent_focus_hit[i]    = b_hit[i][0];
      agent_prio[i*PW +: PW] = PW'(b_pri[i]);
    end
  end

  ipi_dest_resolver #(.N_AGENTS(N), .ID_W(IW), .PRIO_W(PW)) u_ipi_dest_resolver (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_dest(cmd_dest), .sender_id(sender_id), .agent_id(agent_id),
    .agent_ldr(agent_ldr), .agent_fmt(agent_fmt), .agent_focus_off(agent_focus_off),
    .agent_focus_hit(agent_focus_hit), .agent_prio(agent_prio),
    .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_mode(dlv_mode),
    .dlv_vector(dlv_vector), .dlv_trig(dlv_trig), .dlv_level(dlv_level),
    .send_err(send_err)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit e_err = 1'b0;
  bit finished = 1'b0;

  function automatic logic [31:0] mk(int vec, int mode, int lg, int lvl, int trg, int sh);
    return 32'((vec & 255) | ((mode & 7) << 8) | ((lg & 1) << 11) |
               ((lvl & 1) << 14) | ((trg & 1) << 15) | ((sh & 3) << 18));
  endfunction

  // behavioural reference: returns the expected delivery mask
  function automatic logic [N-1:0] model(logic [31:0] w, int d, int s);
    int mode = int'(w[10:8]);
    int lg   = int'(w[11]);
    int sh   = int'(w[19:18]);
    bit c[N];
    logic [N-1:0] r = '0;
    int best = -1;
    if (mode == 5 && w[14] == 1'b0 && w[15] == 1'b1) return '0;
    for (int i = 0; i < N; i++) begin
      c[i] = 0;
      case (sh)
        0: begin
          if (lg == 1) begin
            if (b_fmt[i] == 15) c[i] = ((d & b_ldr[i]) != 0);
            else if (b_fmt[i] == 0)
              c[i] = (d == 255) || (((d >> 4) == (b_ldr[i] >> 4)) && ((d & b_ldr[i] & 15) != 0));
          end else if (mode != 1) c[i] = (d == 255) || (b_id[i] == d);
        end
        1: c[i] = (b_id[i] == s);
        2: c[i] = 1;
        default: c[i] = (b_id[i] != s);
      endcase
    end
    if (mode == 1 && sh != 1) begin
      for (int i = N - 1; i >= 0; i--)
        if (c[i] && b_hit[i] == 1 && b_off[i] == 0) best = i;
      if (best < 0)
        for (int i = 0; i < N; i++)
          if (c[i] && (best < 0 || b_pri[i] < b_pri[best])) best = i;
      if (best >= 0) r[best] = 1'b1;
    end else begin
      for (int i = 0; i < N; i++) r[i] = c[i];
    end
    return r;
  endfunction

  // one clock: drive just after a falling edge, compare after the next one
  task automatic step(bit v, logic [31:0] w, int d, int s, string tag);
    logic [N-1:0] em;
    logic [31:0]  ew;
    bit ok;
    cmd_valid = v; cmd_word = w; cmd_dest = IW'(d); sender_id = IW'(s);
    em = v ? model(w, d, s) : '0;
    ew = w;
    if (v) e_err = !(w[10:8] == 3'd5 && !w[14] && w[15]) && (em == '0);
    @(negedge clk);
    ok = (dlv_valid == v) && (dlv_mask == em) && (send_err == e_err);
    if (v) ok = ok && (dlv_mode == ew[10:8]) && (dlv_vector == ew[7:0]) &&
                (dlv_trig == ew[15]) && (dlv_level == ew[14]);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got v=%0b mask=%b err=%0b mode=%0d vec=%h t=%0b l=%0b exp v=%0b mask=%b err=%0b mode=%0d vec=%h t=%0b l=%0b",
               tag, dlv_valid, dlv_mask, send_err, dlv_mode, dlv_vector, dlv_trig, dlv_level,
               v, em, e_err, ew[10:8], ew[7:0], ew[15], ew[14]);
    end
  endtask

  task automatic cmd(logic [31:0] w, int d, int s, string tag);
    step(1'b1, w, d, s, tag);
  endtask

  task automatic idle(string tag);
    step(1'b0, cmd_word, int'(cmd_dest), int'(sender_id), tag);
  endtask

  task automatic set_agents(int i0, int i1, int i2, int i3);
    b_id[0] = i0; b_id[1] = i1; b_id[2] = i2; b_id[3] = i3;
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    set_agents(3, 5, 6, 9);
    for (int i = 0; i < N; i++) begin
      b_ldr[i] = 1 << i; b_fmt[i] = 15; b_off[i] = 0; b_hit[i] = 0; b_pri[i] = 16 * (i + 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle("R2 reset state");

    // physical destinations
    cmd(mk(8'h31, 0, 0, 1, 0, 0), 5, 3, "R6 R1 physical exact id");
    idle("R2 idle after result");
    cmd(mk(8'h42, 0, 0, 0, 1, 0), 255, 3, "R6 physical broadcast");
    cmd(mk(8'h43, 0, 0, 1, 1, 0), 7, 3, "R13 physical no match");
    idle("R13 error held");
    cmd(mk(8'h44, 1, 0, 0, 0, 0), 5, 3, "R7 physical lowest rejected");
    cmd(mk(8'h45, 1, 0, 0, 0, 0), 255, 3, "R7 physical lowest broadcast rejected");
    cmd(mk(8'h46, 5, 0, 0, 1, 0), 255, 3, "R3 resync dropped");
    cmd(mk(8'h47, 0, 0, 0, 0, 0), 9, 3, "R13 error cleared");
    cmd(mk(8'h00, 5, 0, 0, 1, 2), 0, 3, "R3 resync with broadcast shorthand");
    cmd(mk(8'h48, 5, 0, 1, 1, 2), 0, 3, "R3 init with level set delivered");

    // shorthands
    cmd(mk(8'h50, 0, 0, 0, 0, 1), 0, 6, "R4 self only");
    cmd(mk(8'h51, 1, 1, 0, 0, 1), 0, 9, "R4 self in lowest mode");
    cmd(mk(8'h52, 0, 0, 0, 0, 2), 0, 6, "R5 all including self");
    cmd(mk(8'h53, 0, 0, 0, 0, 3), 0, 3, "R5 all but self");

    // logical flat
    cmd(mk(8'h60, 0, 1, 0, 0, 0), 8'h05, 3, "R8 flat multi match");
    cmd(mk(8'h61, 0, 1, 0, 0, 0), 0, 3, "R8 logical zero destination");
    b_fmt[2] = 4;
    cmd(mk(8'h62, 0, 1, 0, 0, 0), 8'h0F, 3, "R9 unknown format never matches");

    // logical cluster
    for (int i = 0; i < N; i++) b_fmt[i] = 0;
    b_ldr[0] = 8'h11; b_ldr[1] = 8'h12; b_ldr[2] = 8'h21; b_ldr[3] = 8'h13;
    cmd(mk(8'h70, 0, 1, 0, 0, 0), 8'h13, 3, "R9 cluster shared bits");
    cmd(mk(8'h71, 0, 1, 0, 0, 0), 8'hFF, 3, "R9 cluster all");
    cmd(mk(8'h72, 0, 1, 0, 0, 0), 8'h24, 3, "R9 cluster no shared bit");
    cmd(mk(8'h73, 0, 1, 0, 0, 0), 8'h00, 3, "R8 cluster zero destination");

    // lowest priority arbitration over flat logical set
    for (int i = 0; i < N; i++) begin b_fmt[i] = 15; b_ldr[i] = 1 << i; end
    b_pri[0] = 40; b_pri[1] = 20; b_pri[2] = 20; b_pri[3] = 30;
    cmd(mk(8'h80, 1, 1, 0, 0, 0), 8'h0F, 3, "R11 tie to lowest index");
    cmd(mk(8'h81, 1, 1, 0, 0, 0), 8'h0D, 3, "R11 smallest in subset");
    b_hit[3] = 1;
    cmd(mk(8'h82, 1, 1, 0, 0, 0), 8'h0F, 3, "R10 focus beats priority");
    b_hit[2] = 1; b_off[2] = 1;
    cmd(mk(8'h83, 1, 1, 0, 0, 0), 8'h0F, 3, "R10 disabled focus skipped");
    b_off[2] = 0;
    cmd(mk(8'h84, 1, 1, 0, 0, 0), 8'h0F, 3, "R10 lowest focus index");
    cmd(mk(8'h85, 1, 1, 0, 0, 0), 8'h03, 3, "R10 focus outside set ignored");
    b_hit[2] = 0; b_hit[3] = 0;
    cmd(mk(8'h86, 1, 0, 0, 0, 2), 0, 3, "R12 lowest with all shorthand");
    cmd(mk(8'h87, 1, 0, 0, 0, 3), 0, 5, "R12 lowest with others shorthand");
    cmd(mk(8'h88, 1, 1, 0, 0, 0), 8'h00, 3, "R13 lowest with empty set");

    // random configurations against the model
    for (int k = 0; k < 400; k++) begin
      int mds[4] = '{0, 1, 5, 2};
      int fms[3] = '{0, 15, 3};
      int dsel;
      for (int i = 0; i < N; i++) begin
        b_id[i]  = int'($urandom_range(0, 7));
        b_ldr[i] = int'($urandom_range(0, 255));
        b_fmt[i] = fms[$urandom_range(0, 2)];
        b_off[i] = int'($urandom_range(0, 1));
        b_hit[i] = int'($urandom_range(0, 1));
        b_pri[i] = int'($urandom_range(0, 7));
      end
      dsel = int'($urandom_range(0, 9));
      if ($urandom_range(0, 4) == 0) idle("R2 random idle");
      else cmd(mk(int'($urandom_range(0, 255)), mds[$urandom_range(0, 3)],
                  int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                  int'($urandom_range(0, 1)), int'($urandom_range(0, 3))),
               (dsel == 0) ? 255 : (dsel == 1) ? 0 : int'($urandom_range(0, 255)) % ((dsel < 6) ? 8 : 256),
               int'($urandom_range(0, 7)), "R1 R5 R6 R9 R11 random");
    end
    idle("R2 final idle");

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule